// File: doc/BRIEF.md
# Interrupt Pending/Enable Register Block

This block gathers interrupt requests from up to sixteen peripherals and presents a single request line to a processor. Each peripheral raises its request as a one-cycle pulse. The pulse sets a sticky pending bit, and that bit stays set until software clears it. A separate enable register selects which pending bits may reach the processor. The output line is high whenever at least one pending bit is also enabled.

Software reaches both registers through a small word-addressed port with a single-cycle write strobe and a combinational read. A pending bit is acknowledged by writing a word in which that bit is 0. Bits written as 1 keep their current value. Because of this, a handler can clear exactly the sources it serviced without a read-modify-write race against new arrivals. The output line is recomputed from the updated register contents at the same clock edge that commits any register change.

Top module: `irq_pend_ctl`

## Requirements
- R1: After reset, the pending register, the enable register and `irq_o` are all zero.
- R2: A 1 on `src_req[i]` in a cycle sets pending bit i at the next clock edge. Pending bits stay set until cleared by software.
- R3: A write to offset 0x0 replaces the pending bits with (pending AND `wdata[15:0]`), so only bits written as 0 are cleared. With no write and no request, pending holds its value.
- R4: A write to offset 0x4 replaces the whole enable register with `wdata[15:0]`.
- R5: At every clock edge, `irq_o` takes the value of (new pending AND new enable) != 0. It therefore changes at the same edge as the register update that caused it, one cycle after the write or request is presented.
- R6: If a request for bit i and a write clearing bit i fall in the same cycle, bit i ends up set.
- R7: Bits 31:16 of a write have no effect, and bits 31:16 of `rdata` always read 0.
- R8: Reading offset 0x0 returns pending and reading 0x4 returns enable, combinationally from `addr`. Any other offset reads 0, and a write to it changes nothing.
- R9: Pending bit 3 is fed by the DMA controller's interrupt request on `src_req[3]` and behaves like every other bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 16 | One-cycle request pulses, one per source (bit 3: DMA) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The acknowledge write to the pending register and a fresh request for the same bit can land in the same cycle. The bench provokes this by pulsing a source while writing a clearing word that has that bit at 0. It also mixes requests on other bits into cycles that clear them. A behavioural model applies the AND-clear before the OR-set and predicts pending, enable and the line. The design is compared against that model after every clock, including a long stretch of random requests interleaved with random writes to both registers and to an unmapped offset.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_PEND = 2'd1,
      SEL_ENAB = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/irq_pend_decode.sv
module irq_pend_decode
   import irq_pend_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int PEND_OFS = 0,
   parameter int ENAB_OFS = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   output reg_sel_e          sel,
   output logic              wr_pend,
   output logic              wr_enab
);
   generate
      if (PEND_OFS == ENAB_OFS) begin : g_bad_ofs
         $error("pending and enable offsets must differ");
      end
      if (PEND_OFS >= (1 << ADDR_W) || ENAB_OFS >= (1 << ADDR_W)) begin : g_bad_range
         $error("register offset outside address range");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(PEND_OFS);
   localparam logic [ADDR_W-1:0] ENAB_A = ADDR_W'(ENAB_OFS);

   always_comb begin
      if (addr == PEND_A)      sel = SEL_PEND;
      else if (addr == ENAB_A) sel = SEL_ENAB;
      else                     sel = SEL_NONE;
   end

   assign wr_pend = wr_en && (sel == SEL_PEND);
   assign wr_enab = wr_en && (sel == SEL_ENAB);
endmodule

// File: rtl/irq_pend_bits.sv
module irq_pend_bits #(
   parameter int N_SRC = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_req,
   input  logic             wr_pend,
   input  logic [N_SRC-1:0] wbits,
   output logic [N_SRC-1:0] pend_d,
   output logic [N_SRC-1:0] pend_q
);
   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_bit
         // acknowledge first, then a concurrent request sets the bit again
         always_comb begin
            pend_d[i] = pend_q[i];
            if (wr_pend) pend_d[i] = pend_q[i] & wbits[i];
            if (src_req[i]) pend_d[i] = 1'b1;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q[i] <= 1'b0;
            else        pend_q[i] <= pend_d[i];
         end

         p_req_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            src_req[i] |=> pend_q[i]);
         p_req_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_pend && !wbits[i] && src_req[i]) |=> pend_q[i]);
         p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_pend && !wbits[i] && !src_req[i]) |=> !pend_q[i]);
         p_one_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!src_req[i] && (!wr_pend || wbits[i])) |=> (pend_q[i] == $past(pend_q[i])));
      end
   endgenerate
endmodule

// File: rtl/irq_enab_reg.sv
module irq_enab_reg #(
   parameter int N_SRC = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_enab,
   input  logic [N_SRC-1:0] wbits,
   output logic [N_SRC-1:0] enab_d,
   output logic [N_SRC-1:0] enab_q
);
   assign enab_d = wr_enab ? wbits : enab_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) enab_q <= '0;
      else        enab_q <= enab_d;
   end

   p_enab_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_enab |=> (enab_q == $past(wbits)));
   p_enab_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_enab |=> $stable(enab_q));
endmodule

// File: rtl/irq_pend_ctl.sv
module irq_pend_ctl
   import irq_pend_pkg::*;
#(
   parameter int N_SRC    = 16,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4,
   parameter int PEND_OFS = 0,
   parameter int ENAB_OFS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_req,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq_o
);
   localparam int PAD_W = DATA_W - N_SRC;

   generate
      if (N_SRC < 1 || N_SRC >= DATA_W) begin : g_bad_width
         $error("N_SRC must be at least 1 and narrower than DATA_W");
      end
   endgenerate

   reg_sel_e         sel;
   logic             wr_pend, wr_enab;
   logic [N_SRC-1:0] pend_d, pend_q, enab_d, enab_q;
   logic             upper_set;

   assign upper_set = |wdata[DATA_W-1:N_SRC];

   irq_pend_decode #(
      .ADDR_W(ADDR_W), .PEND_OFS(PEND_OFS), .ENAB_OFS(ENAB_OFS)
   ) u_dec (
      .addr(addr), .wr_en(wr_en), .sel(sel), .wr_pend(wr_pend), .wr_enab(wr_enab)
   );

   irq_pend_bits #(.N_SRC(N_SRC)) u_pend (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .wr_pend(wr_pend),
      .wbits(wdata[N_SRC-1:0]), .pend_d(pend_d), .pend_q(pend_q)
   );

   irq_enab_reg #(.N_SRC(N_SRC)) u_enab (
      .clk(clk), .rst_n(rst_n), .wr_enab(wr_enab),
      .wbits(wdata[N_SRC-1:0]), .enab_d(enab_d), .enab_q(enab_q)
   );

   // line follows the post-update contents, so it moves with the registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |(pend_d & enab_d);
   end

   always_comb begin
      unique case (sel)
         SEL_PEND: rdata = {{PAD_W{1'b0}}, pend_q};
         SEL_ENAB: rdata = {{PAD_W{1'b0}}, enab_q};
         default:  rdata = '0;
      endcase
   end

   p_line_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == |(pend_q & enab_q));
   p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[DATA_W-1:N_SRC] == '0);
   p_upper_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_enab && upper_set) |=> (enab_q == $past(wdata[N_SRC-1:0])));
   p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |-> (rdata == '0));
endmodule

// File: tb/irq_pend_ctl_test.sv
`timescale 1ns/1ps
module irq_pend_ctl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] src_req = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   int m_pend = 0;
   int m_enab = 0;
   int m_irq  = 0;

   always #2.5 clk = ~clk;

   irq_pend_ctl uut (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
      end
   endtask

   // compare every visible piece of state against the model
   task automatic observe(input string tag);
      addr = 4'h0; #0.5;
      check(tag, "pending read", int'(rdata), m_pend);
      addr = 4'h4; #0.5;
      check(tag, "enable read", int'(rdata), m_enab);
      addr = 4'h8; #0.5;
      check("R8", "unmapped read", int'(rdata), 0);
      check(tag, "irq line", int'(irq_o), m_irq);
   endtask

   // one clock: drive at negedge, model at posedge, observe after
   task automatic step(input string tag, input logic [15:0] rq, input logic we,
                       input logic [3:0] ad, input logic [31:0] wd);
      src_req = rq; wr_en = we; addr = ad; wdata = wd;
      @(posedge clk);
      if (we && ad == 4'h0) m_pend = m_pend & int'(wd[15:0]);
      m_pend = m_pend | int'(rq);
      if (we && ad == 4'h4) m_enab = int'(wd[15:0]);
      m_irq = ((m_pend & m_enab) != 0) ? 1 : 0;
      @(negedge clk);
      src_req = '0; wr_en = 1'b0; wdata = '0;
      observe(tag);
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      observe("R1");
      rst_n = 1'b1;
      @(negedge clk);
      observe("R1");

      // R2: requests latch and are sticky; R9: DMA source on bit 3
      step("R2", 16'h0001, 0, 4'h0, 0);
      step("R9", 16'h0008, 0, 4'h0, 0);
      step("R2", 16'h8400, 0, 4'h0, 0);
      step("R2", 16'h0000, 0, 4'h0, 0);
      // R4 / R5: enable a pending bit, line rises with the register
      step("R4", 16'h0000, 1, 4'h4, 32'h0000_0010);
      step("R5", 16'h0000, 1, 4'h4, 32'h0000_0008);
      step("R5", 16'h0010, 0, 4'h0, 0);
      // R3: clear bit 3 only, then clear everything
      step("R3", 16'h0000, 1, 4'h0, 32'h0000_FFF7);
      step("R3", 16'h0000, 1, 4'h0, 32'h0000_FFFF);
      step("R3", 16'h0000, 1, 4'h0, 32'h0000_0000);
      // R6: request and clear of the same bit in one cycle
      step("R6", 16'h0010, 1, 4'h0, 32'h0000_0000);
      step("R6", 16'h0011, 1, 4'h0, 32'h0000_FFEF);
      // R7: upper half of writes ignored
      step("R7", 16'h0000, 1, 4'h4, 32'hABCD_1234);
      step("R7", 16'h0000, 1, 4'h0, 32'hFFFF_0000);
      step("R7", 16'h00F0, 1, 4'h0, 32'h0001_FFFF);
      // R8: write to an unmapped offset changes nothing
      step("R8", 16'h0000, 1, 4'h8, 32'h0000_0000);
      step("R8", 16'h0000, 1, 4'hC, 32'h0000_FFFF);
      // R5: disable all, line drops
      step("R5", 16'h0000, 1, 4'h4, 32'h0000_0000);

      for (int k = 0; k < 400; k++) begin
         logic [15:0] rq;
         logic [31:0] wd;
         logic [3:0]  ad;
         rq = 16'($urandom) & 16'($urandom) & 16'($urandom);
         wd = $urandom;
         case ($urandom % 4)
            0: ad = 4'h0;
            1: ad = 4'h4;
            2: ad = 4'h8;
            default: ad = 4'h0;
         endcase
         step("R6", rq, 1'($urandom), ad, wd);
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule